// File: doc/BRIEF.md
# MDIO Clause 22 Management Master

This block is a station-management master for the two-wire MDC/MDIO bus. On a start strobe it builds a Clause 22 read or write frame from a read/write flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. It derives MDC from the system clock and shifts the frame out on MDIO. It exposes MDIO as separate output, output-enable and input pins, so that a pad or a testbench can form the tri-state line with its pull-up.

MDIO changes only while MDC is low. This gives a full half period of setup and hold around each MDC rising edge, which is the edge on which the PHY samples. During a read, the master releases the line for the turnaround and data bits and samples the PHY on MDC rising edges. The captured word appears on `rd_data` together with a one-cycle `done` pulse.

By default no preamble is sent, so a frame is 32 MDC cycles. A runtime input can prefix a run of ones. After reset the block stays busy for one MDC period before it accepts its first request.

Top module: `mdio_master`

## Requirements
- R1: A frame is sent MSB first on MDIO, one bit per MDC cycle, in this order: start code 01, opcode (10 = read, 01 = write, with `rd_nwr` = 1 meaning read), 5-bit PHY address, 5-bit register address, 2 turnaround bits, 16 data bits. For a write, the 16 data bits are `wr_data`.
- R2: With `pre_en` = 0, a frame has exactly 32 MDC rising edges. `done` is high on the (64·HALF_PERIOD+1)-th clock sample after the start request was taken.
- R3: With `pre_en` = 1, PREAMBLE_LEN (default 32, at least 32) driven ones come before the start code. The frame then has 64 MDC rising edges.
- R4: In a write, the master drives the turnaround bits as 10. In a read, `mdio_oe` is low for both turnaround bits and all 16 data bits, and high for the first 14 bits.
- R5: In a read, MDIO is sampled on MDC rising edges. `rd_data` holds the 16 data bits from the `done` cycle onward and is not changed by a later write.
- R6: `mdio_o` and `mdio_oe` never change while MDC is high.
- R7: Each MDC high phase and each in-frame low phase lasts HALF_PERIOD system clocks. MDC is low whenever the block is not busy. Elaboration rejects an MDC rate above 25 MHz.
- R8: After reset is released, `busy` stays high for 2·HALF_PERIOD clock edges (one MDC period). A start during that time is ignored.
- R9: A start request while `busy` is high is ignored and does not alter the frame in progress.
- R10: `done` is a single-cycle pulse at the MDC falling edge that ends the last bit. `busy` is low in that cycle.
- R11: While idle, `mdio_oe` is low and `mdio_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a frame; taken only when not busy |
| rd_nwr | input | 1 | 1 = read frame, 0 = write frame |
| pre_en | input | 1 | Send the preamble before the frame |
| phy_addr | input | 5 | PHY address field |
| reg_addr | input | 5 | Register address field |
| wr_data | input | 16 | Data for a write frame |
| rd_data | output | 16 | Data from the last completed read |
| busy | output | 1 | Frame or post-reset wait in progress |
| done | output | 1 | One-cycle pulse at frame end |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Sampled MDIO line |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO drive enable |

## Verification
The hardest case is the hand-over of the line during a read. The master must release MDIO before the PHY drives the second turnaround bit, and it must sample each data bit on the correct rising edge. The bench holds a PHY model that counts MDC rising edges and drives its reply on falling edges. It flags any edge where both sides drive, so a one-bit slip in release or capture shows up as a contention count or a shifted word. A second hard case is a start request in the middle of a frame. The bench injects one with inverted fields and then checks that the completed frame on the wire is the original one.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   localparam int          FRAME_BITS = 32;
   localparam logic [1:0]  CODE_START = 2'b01;
   localparam logic [1:0]  CODE_RD    = 2'b10;
   localparam logic [1:0]  CODE_WR    = 2'b01;
   localparam logic [1:0]  TURN_WR    = 2'b10;
   localparam int          HDR_BITS   = 14;

   typedef enum logic [1:0] {
      CS_RSTWAIT = 2'd0,
      CS_IDLE    = 2'd1,
      CS_RUN     = 2'd2
   } ctrl_st_t;

   typedef struct packed {
      logic        rd;
      logic [4:0]  phy;
      logic [4:0]  regad;
      logic [15:0] wdat;
   } mdio_req_t;

   // Bit pattern driven on the wire for one frame, MSB first.
   function automatic logic [FRAME_BITS-1:0] frame_bits(input mdio_req_t r);
      return {CODE_START, (r.rd ? CODE_RD : CODE_WR), r.phy, r.regad,
              (r.rd ? 2'b11 : TURN_WR), (r.rd ? 16'hFFFF : r.wdat)};
   endfunction

   // Drive-enable pattern: reads release the line after the header.
   function automatic logic [FRAME_BITS-1:0] frame_oe(input logic rd);
      return rd ? {{HDR_BITS{1'b1}}, {(FRAME_BITS-HDR_BITS){1'b0}}}
                : {FRAME_BITS{1'b1}};
   endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int HALF_PERIOD = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_stb,
   output logic fall_stb
);
   localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

   logic tick;

   generate
      if (HALF_PERIOD == 1) begin : g_nocnt
         assign tick = run;
      end else begin : g_cnt
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              cnt <= '0;
            else if (!run)                           cnt <= '0;
            else if (cnt == CW'(HALF_PERIOD - 1))    cnt <= '0;
            else                                     cnt <= cnt + CW'(1);
         end
         assign tick = run && (cnt == CW'(HALF_PERIOD - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mdc <= 1'b0;
      else if (!run)   mdc <= 1'b0;
      else if (tick)   mdc <= ~mdc;
   end

   assign rise_stb = tick & ~mdc;
   assign fall_stb = tick &  mdc;

   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_stb && fall_stb));                                   // R7
   AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |=> mdc);                                          // R7

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
   import mdio_pkg::*;
#(
   parameter int PRE_SUPPORT  = 1,
   parameter int PREAMBLE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  mdio_req_t   req,
   input  logic        pre_en,
   input  logic        shift,
   input  logic        sample,
   input  logic        mdio_i,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic [15:0] cap
);
   localparam int PRE_W = (PRE_SUPPORT != 0) ? PREAMBLE_LEN : 0;
   localparam int SH_W  = FRAME_BITS + PRE_W;

   logic [SH_W-1:0]       dat_q, oe_q, dat_ld, oe_ld;
   logic [FRAME_BITS-1:0] fr_d, fr_oe;

   assign fr_d  = frame_bits(req);
   assign fr_oe = frame_oe(req.rd);

   generate
      if (PRE_SUPPORT != 0) begin : g_pre
         assign dat_ld = pre_en ? {{PRE_W{1'b1}}, fr_d}  : {fr_d,  {PRE_W{1'b1}}};
         assign oe_ld  = pre_en ? {{PRE_W{1'b1}}, fr_oe} : {fr_oe, {PRE_W{1'b0}}};
      end else begin : g_nopre
         logic unused_pre;
         assign unused_pre = pre_en;
         assign dat_ld = fr_d;
         assign oe_ld  = fr_oe;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_q <= '1;
         oe_q  <= '0;
      end else if (load) begin
         dat_q <= dat_ld;
         oe_q  <= oe_ld;
      end else if (shift) begin
         dat_q <= {dat_q[SH_W-2:0], 1'b1};
         oe_q  <= {oe_q[SH_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap <= '0;
      else if (sample) cap <= {cap[14:0], mdio_i};
   end

   assign mdio_o  = dat_q[SH_W-1];
   assign mdio_oe = oe_q[SH_W-1];

   AST_NO_LOAD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && sample));                                         // R5

endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
   import mdio_pkg::*;
#(
   parameter int HALF_PERIOD  = 3,
   parameter int PRE_SUPPORT  = 1,
   parameter int PREAMBLE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        rd_nwr,
   input  logic        pre_en,
   input  logic        fall_stb,
   input  logic [15:0] cap,
   output logic        busy,
   output logic        run,
   output logic        load,
   output logic        done,
   output logic [15:0] rd_data
);
   localparam int WAIT_CYC = 2 * HALF_PERIOD;
   localparam int WCW      = $clog2(WAIT_CYC + 1);
   localparam int MAXB     = FRAME_BITS + ((PRE_SUPPORT != 0) ? PREAMBLE_LEN : 0);
   localparam int BCW      = $clog2(MAXB + 1);

   ctrl_st_t       st;
   logic [WCW-1:0] wcnt;
   logic [BCW-1:0] bcnt, last_idx;
   logic           rd_q, use_pre, last_bit;

   assign use_pre  = (PRE_SUPPORT != 0) && pre_en;
   assign load     = (st == CS_IDLE) && start;
   assign run      = (st == CS_RUN);
   assign busy     = (st != CS_IDLE);
   assign last_bit = run && fall_stb && (bcnt == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= CS_RSTWAIT;
         wcnt     <= '0;
         bcnt     <= '0;
         last_idx <= '0;
         rd_q     <= 1'b0;
         done     <= 1'b0;
         rd_data  <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            CS_RSTWAIT: begin
               wcnt <= wcnt + WCW'(1);
               if (wcnt == WCW'(WAIT_CYC - 1)) st <= CS_IDLE;
            end
            CS_IDLE: begin
               if (start) begin
                  st       <= CS_RUN;
                  bcnt     <= '0;
                  rd_q     <= rd_nwr;
                  last_idx <= use_pre ? BCW'(MAXB - 1) : BCW'(FRAME_BITS - 1);
               end
            end
            CS_RUN: begin
               if (last_bit) begin
                  st   <= CS_IDLE;
                  done <= 1'b1;
                  if (rd_q) rd_data <= cap;
               end else if (fall_stb) begin
                  bcnt <= bcnt + BCW'(1);
               end
            end
            default: st <= CS_IDLE;
         endcase
      end
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                            // R10
   AST_DONE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                            // R10
   AST_BUSY_START_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (run && start && !fall_stb) |=> $stable(bcnt) && $stable(rd_q)); // R9
   AST_WAIT_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CS_RSTWAIT) |-> !load);                              // R8
   AST_RDDATA_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> ($stable(rd_data) || done));                       // R5

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int SYS_CLK_HZ   = 50_000_000,
   parameter int HALF_PERIOD  = 3,
   parameter int PRE_SUPPORT  = 1,
   parameter int PREAMBLE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        rd_nwr,
   input  logic        pre_en,
   input  logic [4:0]  phy_addr,
   input  logic [4:0]  reg_addr,
   input  logic [15:0] wr_data,
   output logic [15:0] rd_data,
   output logic        busy,
   output logic        done,
   output logic        mdc,
   input  logic        mdio_i,
   output logic        mdio_o,
   output logic        mdio_oe
);
   localparam longint MDC_HZ = longint'(SYS_CLK_HZ) / (2 * longint'(HALF_PERIOD));

   generate
      if (HALF_PERIOD < 1) begin : g_bad_half
         $error("HALF_PERIOD must be at least 1");
      end
      if (MDC_HZ > 25_000_000) begin : g_bad_rate
         $error("MDC rate exceeds 25 MHz");
      end
      if (PRE_SUPPORT != 0 && PREAMBLE_LEN < 32) begin : g_bad_pre
         $error("PREAMBLE_LEN must be at least 32");
      end
   endgenerate

   logic        run, load, rise_stb, fall_stb;
   logic [15:0] cap;
   mdio_req_t   req;

   assign req = '{rd: rd_nwr, phy: phy_addr, regad: reg_addr, wdat: wr_data};

   mdio_clkgen #(.HALF_PERIOD(HALF_PERIOD)) clkgen_i (
      .clk(clk), .rst_n(rst_n), .run(run),
      .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
   );

   mdio_shifter #(.PRE_SUPPORT(PRE_SUPPORT), .PREAMBLE_LEN(PREAMBLE_LEN)) shifter_i (
      .clk(clk), .rst_n(rst_n), .load(load), .req(req), .pre_en(pre_en),
      .shift(fall_stb), .sample(rise_stb), .mdio_i(mdio_i),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cap(cap)
   );

   mdio_ctrl #(.HALF_PERIOD(HALF_PERIOD), .PRE_SUPPORT(PRE_SUPPORT),
               .PREAMBLE_LEN(PREAMBLE_LEN)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr), .pre_en(pre_en),
      .fall_stb(fall_stb), .cap(cap), .busy(busy), .run(run), .load(load),
      .done(done), .rd_data(rd_data)
   );

   AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));             // R6
   AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);                                            // R7
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdio_oe && mdio_o));                            // R11

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
   localparam int HALF = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, rd_nwr = 1'b0, pre_en = 1'b0;
   logic [4:0]  phy_addr = '0, reg_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        busy, done, mdc, mdio_o, mdio_oe;
   logic        line;

   int checks = 0, fails = 0, cyc = 0;

   // PHY model state
   logic        phy_oe = 1'b0, phy_o = 1'b1;
   logic        phy_rd = 1'b0;
   logic [15:0] phy_val = '0;
   int          phy_off = 0, rise_cnt = 0, contention = 0;
   logic [63:0] rx_bits = '0, rx_oe = '0;
   int          setup_bad = 0, hi_bad = 0, lo_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   assign line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

   mdio_master dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr), .pre_en(pre_en),
      .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
      .rd_data(rd_data), .busy(busy), .done(done), .mdc(mdc),
      .mdio_i(line), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );

   always @(posedge mdc) begin
      rx_bits = {rx_bits[62:0], line};
      rx_oe   = {rx_oe[62:0], mdio_oe};
      if (mdio_oe && phy_oe) contention++;
      rise_cnt++;
   end

   always @(negedge mdc) begin
      int idx;
      idx = rise_cnt - phy_off;
      if (phy_rd && idx == 15) begin
         phy_oe = 1'b1; phy_o = 1'b0;
      end else if (phy_rd && idx >= 16 && idx <= 31) begin
         phy_oe = 1'b1; phy_o = phy_val[31-idx];
      end else begin
         phy_oe = 1'b0; phy_o = 1'b1;
      end
   end

   // Timing monitors, sampled away from the active edge
   logic p_mdc = 1'b0, p_o = 1'b1, p_oe = 1'b0, seen_fall = 1'b0;
   int   hi_len = 0, lo_len = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (mdc && (mdio_o !== p_o || mdio_oe !== p_oe)) setup_bad++;
         if (mdc) hi_len++; else lo_len++;
         if (p_mdc && !mdc) begin
            if (hi_len != HALF) hi_bad++;
            hi_len = 0; lo_len = 1; seen_fall = 1'b1;
         end
         if (!p_mdc && mdc) begin
            if (seen_fall && lo_len != HALF) lo_bad++;
            lo_len = 0; hi_len = 1;
         end
         if (!busy) seen_fall = 1'b0;
      end
      p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
         finish_run();
      end
   end

   // Drive one frame; returns samples from request to done.
   task automatic run_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] wd, input logic [15:0] val,
                            input bit pre, input bit poke, output int dur);
      phy_rd = rd; phy_val = val; phy_off = pre ? 32 : 0;
      rise_cnt = 0; contention = 0; setup_bad = 0; hi_bad = 0; lo_bad = 0;
      rx_bits = '0; rx_oe = '0;
      rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; pre_en = pre;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0; dur = 1;
      while (!done && dur < 5000) begin
         @(negedge clk); dur++;
         if (poke && dur == 40) begin
            start = 1'b1; rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra;
            wr_data = ~wd; pre_en = ~pre;
         end else begin
            start = 1'b0; rd_nwr = rd; phy_addr = pa; reg_addr = ra;
            wr_data = wd; pre_en = pre;
         end
      end
      chk(done === 1'b1, "R10", "done seen", done, 1);
      chk(busy === 1'b0, "R10", "busy low with done", busy, 0);
      @(negedge clk);
      chk(done === 1'b0, "R10", "done one cycle", done, 0);
      chk(mdio_oe === 1'b0 && mdio_o === 1'b1, "R11", "idle line released",
          {mdio_oe, mdio_o}, 2'b01);
      chk(mdc === 1'b0, "R7", "mdc low idle", mdc, 0);
      chk(setup_bad == 0, "R6", "output change while mdc high", setup_bad, 0);
      chk(hi_bad == 0 && lo_bad == 0, "R7", "mdc phase length", hi_bad + lo_bad, 0);
   endtask

   task automatic test_reset_wait();
      int nbusy;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(mdc === 1'b0 && mdio_oe === 1'b0 && mdio_o === 1'b1 && done === 1'b0,
          "R11", "reset state", {mdc, mdio_oe, mdio_o, done}, 4'b0010);
      rst_n = 1'b1; rise_cnt = 0; nbusy = 0;
      start = 1'b1; rd_nwr = 1'b0;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 4 * HALF; i++) begin
         if (busy) nbusy++;
         @(negedge clk);
      end
      chk(nbusy == 2 * HALF - 1, "R8", "post-reset busy samples", nbusy, 2 * HALF - 1);
      repeat (10) @(negedge clk);
      chk(rise_cnt == 0 && !busy, "R8", "start during wait ignored", rise_cnt, 0);
   endtask

   task automatic test_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
      int dur;
      run_frame(1'b0, pa, ra, wd, 16'h0, 1'b0, 1'b0, dur);
      chk(rise_cnt == 32, "R2", "write mdc edges", rise_cnt, 32);
      chk(dur == 64 * HALF + 1, "R2", "write duration", dur, 64 * HALF + 1);
      chk(rx_bits[31:0] == {2'b01, 2'b01, pa, ra, 2'b10, wd}, "R1", "write frame bits",
          rx_bits[31:0], {2'b01, 2'b01, pa, ra, 2'b10, wd});
      chk(rx_oe[31:0] == 32'hFFFF_FFFF && rx_bits[17:16] == 2'b10, "R4",
          "write turnaround driven 10", {rx_oe[31:0], rx_bits[17:16]}, {32'hFFFF_FFFF, 2'b10});
   endtask

   task automatic test_read(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] val);
      int dur;
      run_frame(1'b1, pa, ra, 16'h0, val, 1'b0, 1'b0, dur);
      chk(rise_cnt == 32, "R2", "read mdc edges", rise_cnt, 32);
      chk(rx_bits[31:18] == {2'b01, 2'b10, pa, ra}, "R1", "read header bits",
          rx_bits[31:18], {2'b01, 2'b10, pa, ra});
      chk(rx_oe[31:0] == {14'h3FFF, 18'h0}, "R4", "read release pattern",
          rx_oe[31:0], {14'h3FFF, 18'h0});
      chk(contention == 0, "R4", "bus contention", contention, 0);
      chk(rd_data == val, "R5", "read data", rd_data, val);
   endtask

   task automatic test_preamble(input bit rd, input logic [15:0] v);
      int dur;
      run_frame(rd, 5'h00, 5'h02, v, v, 1'b1, 1'b0, dur);
      chk(rise_cnt == 64, "R3", "preamble frame edges", rise_cnt, 64);
      chk(rx_bits[63:32] == 32'hFFFF_FFFF && rx_oe[63:32] == 32'hFFFF_FFFF, "R3",
          "preamble driven ones", rx_bits[63:32] & rx_oe[63:32], 32'hFFFF_FFFF);
      chk(dur == 128 * HALF + 1, "R3", "preamble duration", dur, 128 * HALF + 1);
      if (rd) chk(rd_data == v, "R5", "read data after preamble", rd_data, v);
      else    chk(rx_bits[31:0] == {4'b0101, 10'h002, 2'b10, v}, "R1",
                  "write bits after preamble", rx_bits[31:0], {4'b0101, 10'h002, 2'b10, v});
   endtask

   task automatic test_busy_ignore();
      int dur;
      run_frame(1'b0, 5'h03, 5'h11, 16'hC3A5, 16'h0, 1'b0, 1'b1, dur);
      repeat (20) @(negedge clk);
      chk(rise_cnt == 32 && !busy, "R9", "no second frame", rise_cnt, 32);
      chk(rx_bits[31:0] == {4'b0101, 5'h03, 5'h11, 2'b10, 16'hC3A5}, "R9",
          "frame unaltered by busy start", rx_bits[31:0],
          {4'b0101, 5'h03, 5'h11, 2'b10, 16'hC3A5});
   endtask

   task automatic test_rd_hold();
      int dur;
      run_frame(1'b1, 5'h00, 5'h01, 16'h0, 16'h796D, 1'b0, 1'b0, dur);
      run_frame(1'b0, 5'h00, 5'h04, 16'h1234, 16'hFFFF, 1'b0, 1'b0, dur);
      chk(rd_data == 16'h796D, "R5", "rd_data held over write", rd_data, 16'h796D);
   endtask

   initial begin
      test_reset_wait();
      test_write(5'h00, 5'h0E, 16'h001F);
      test_write(5'h1F, 5'h00, 16'hFFFF);
      test_write(5'h0A, 5'h15, 16'h0000);
      test_read(5'h00, 5'h03, 16'hA231);
      test_read(5'h15, 5'h0A, 16'h5A5A);
      test_read(5'h00, 5'h1F, 16'h8001);
      test_preamble(1'b0, 16'hBEEF);
      test_preamble(1'b1, 16'h0F0F);
      test_busy_ignore();
      test_rd_hold();
      finish_run();
   end

endmodule